// File: doc/BRIEF.md
# Tolerant Configuration Address Latch

This block is the address/data register pair through which a host bridge reaches the configuration space of devices below it. Software writes a 32-bit configuration address into the address register at window offset 0. The block corrects the value as it is stored: the two lowest bits are cleared and the top (enable) bit is set. Software that leaves the enable bit clear, or puts junk in the low bits, therefore still gets working configuration cycles. Only a full-word write at offset 0 is accepted; any narrower or offset write to the address register is discarded.

Accesses to the data port, at window offset 4, are passed straight on to a configuration-space backend in the same cycle. The request carries the bus, device, function and register-dword fields taken from the stored address, byte enables built from the access size and the low offset bits, and the write data. Read data from either register comes back one cycle after the read. It is little-endian, and byte lanes outside the access are forced to zero.

Top module: `cfg_addr_latch`

## Requirements
- R1: After reset, the address register reads as 0, `acc_rvalid` is low, and `cfg_req` is low while no access is presented.
- R2: A write at window offset 0 with size code 2 (4 bytes) stores the written word with bits 1:0 cleared and bit 31 set. A later full read at offset 0 returns that value.
- R3: A write to the address region (offsets 0 to 3) that is not size code 2 at offset 0 leaves the address register unchanged.
- R4: A data-port access (offsets 4 to 7) with a valid size raises `cfg_req` in the same cycle. The fields are bus = address bits 23:16, device = bits 15:11, function = bits 10:8 and dword = bits 7:2 of the stored address.
- R5: Size codes 0, 1 and 2 mean 1, 2 and 4 bytes. `cfg_be` is that many ones shifted left by offset bits 1:0, with lanes beyond byte 3 dropped.
- R6: A data-port write drives `cfg_we` high and `cfg_wdata` equal to `acc_wdata` with the bytes outside `cfg_be` zeroed. A data-port read drives `cfg_we` low.
- R7: Every read raises `acc_rvalid` for one cycle on the next clock. `acc_rdata` then carries the selected register (stored address, or `cfg_rdata` sampled in the access cycle), with the byte lanes outside the access set to zero. Byte k sits in bits 8k+7:8k.
- R8: Size code 3 is invalid. It raises no `cfg_req`, changes no state, and a read with it returns zero data.
- R9: Data-port accesses never change the address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 3 | Byte offset within the register window |
| acc_size | input | 2 | Size code: 0 byte, 1 half, 2 word, 3 invalid |
| acc_wdata | input | 32 | Lane-aligned write data |
| acc_rdata | output | 32 | Read data, valid with acc_rvalid |
| acc_rvalid | output | 1 | Read data valid, one cycle after the read |
| cfg_req | output | 1 | Configuration request to the backend |
| cfg_we | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_dword | output | 6 | Target register dword index |
| cfg_be | output | 4 | Byte enables of the request |
| cfg_wdata | output | 32 | Write data with disabled lanes zeroed |
| cfg_rdata | input | 32 | Backend read data, same cycle as cfg_req |

## Verification
The bench sweeps every offset and size code for both reads and writes, with address values whose enable bit is clear and whose low bits are set. A latch that skipped the fixup would read back with bit 31 clear or bits 1:0 set. One that accepted narrow or offset writes would lose its stored value. The data-port sweep covers offsets near the top of the dword, where a wrong shift or a missing truncation would give the wrong byte enables or leak stray lanes into write or read data. It also reads the address back after each data-port pass, so a design that let data-port writes reach the address register would show up there.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  // Size code of a window access
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  // Field layout of a stored configuration address
  localparam int unsigned FLD_LO    = 2;   // lowest bit of the dword index
  localparam int unsigned FLD_HI    = 23;  // highest bit of the bus number
  localparam int unsigned FLD_W     = FLD_HI - FLD_LO + 1;
  localparam int unsigned BUS_W     = 8;
  localparam int unsigned DEV_W     = 5;
  localparam int unsigned FN_W      = 3;
  localparam int unsigned DWORD_W   = 6;

  typedef struct packed {
    logic [BUS_W-1:0]   bus;
    logic [DEV_W-1:0]   dev;
    logic [FN_W-1:0]    fn;
    logic [DWORD_W-1:0] dword;
  } cfg_target_t;

  // Window regions selected by the offset bits above the lane bits
  localparam int unsigned REGION_ADDR = 0;
  localparam int unsigned REGION_DATA = 1;

endpackage

// File: rtl/cfgl_lane_dec.sv
module cfgl_lane_dec
  import cfgl_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input  logic [1:0]         size_code,
  input  logic [LANE_W-1:0]  lane_off,
  output logic               size_ok,
  output logic [LANES-1:0]   be,
  output logic [8*LANES-1:0] lane_mask
);

  localparam int unsigned WIDE_W = 2 * LANES;

  acc_size_e          size_e;
  logic [WIDE_W-1:0]  base;
  logic [WIDE_W-1:0]  shifted;

  assign size_e = acc_size_e'(size_code);

  always_comb begin
    base    = '0;
    size_ok = 1'b1;
    case (size_e)
      SZ_BYTE: base[0]       = 1'b1;
      SZ_HALF: base[1:0]     = 2'b11;
      SZ_WORD: base[LANES-1:0] = '1;
      default: size_ok       = 1'b0;
    endcase
  end

  // Lanes pushed beyond the top of the word are dropped
  assign shifted = base << lane_off;
  assign be      = shifted[LANES-1:0];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_mask[8*k +: 8] = {8{be[k]}};
  end

endmodule

// File: rtl/cfgl_addr_reg.sv
module cfgl_addr_reg #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned EN_BIT  = DATA_W - 1,
  parameter int unsigned CLR_LOW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] addr_q
);

  localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((1 << CLR_LOW) - 1);
  localparam logic [DATA_W-1:0] EN_MASK  = DATA_W'(1) << EN_BIT;

  logic [DATA_W-1:0] addr_d;

  // Next state: corrected value on an accepted write, else hold
  always_comb begin
    addr_d = addr_q;
    if (wr_hit) begin
      addr_d = (wdata & ~LOW_MASK) | EN_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (wr_hit) begin
      addr_q <= addr_d;
    end
  end

  AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q != $past(addr_q)) |-> (addr_q[EN_BIT] && ((addr_q & LOW_MASK) == '0))); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(addr_q)); // R3

endmodule

// File: rtl/cfgl_field_split.sv
module cfgl_field_split
  import cfgl_pkg::*;
(
  input  logic [FLD_W-1:0] fld_bits,
  output cfg_target_t      target
);

  // Bus, device, function and dword occupy the field bits in that order, high to low
  assign target = cfg_target_t'(fld_bits);

endmodule

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch
  import cfgl_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFF_W  = 3,
  localparam int unsigned LANES  = DATA_W / 8,
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned SEL_W  = OFF_W - LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [OFF_W-1:0]  acc_offset,
  input  logic [1:0]        acc_size,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              acc_rvalid,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [BUS_W-1:0]  cfg_bus,
  output logic [DEV_W-1:0]  cfg_dev,
  output logic [FN_W-1:0]   cfg_fn,
  output logic [DWORD_W-1:0] cfg_dword,
  output logic [LANES-1:0]  cfg_be,
  output logic [DATA_W-1:0] cfg_wdata,
  input  logic [DATA_W-1:0] cfg_rdata
);

  localparam logic [SEL_W-1:0] SEL_ADDR = SEL_W'(REGION_ADDR);
  localparam logic [SEL_W-1:0] SEL_DATA = SEL_W'(REGION_DATA);

  logic [SEL_W-1:0]  region;
  logic [LANE_W-1:0] lane_off;
  logic              size_ok;
  logic [LANES-1:0]  be;
  logic [DATA_W-1:0] lane_mask;
  logic              wr_hit;
  logic              dp_hit;
  logic              rd_hit;
  logic [DATA_W-1:0] addr_q;
  cfg_target_t       target;

  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  assign region   = acc_offset[OFF_W-1:LANE_W];
  assign lane_off = acc_offset[LANE_W-1:0];

  cfgl_lane_dec #(.LANES(LANES)) u_lanes (
    .size_code (acc_size),
    .lane_off  (lane_off),
    .size_ok   (size_ok),
    .be        (be),
    .lane_mask (lane_mask)
  );

  // Address register accepts only an aligned full-word write
  assign wr_hit = acc_valid && acc_write && (region == SEL_ADDR) &&
                  (lane_off == '0) && (acc_size_e'(acc_size) == SZ_WORD);

  cfgl_addr_reg #(.DATA_W(DATA_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_hit),
    .wdata  (acc_wdata),
    .addr_q (addr_q)
  );

  cfgl_field_split u_split (
    .fld_bits (addr_q[FLD_HI:FLD_LO]),
    .target   (target)
  );

  // Data port forwards to the backend in the access cycle
  assign dp_hit    = acc_valid && (region == SEL_DATA) && size_ok;
  assign cfg_req   = dp_hit;
  assign cfg_we    = dp_hit && acc_write;
  assign cfg_bus   = target.bus;
  assign cfg_dev   = target.dev;
  assign cfg_fn    = target.fn;
  assign cfg_dword = target.dword;
  assign cfg_be    = dp_hit ? be : '0;
  assign cfg_wdata = acc_wdata & lane_mask;

  // Read return path: next state
  assign rd_hit = acc_valid && !acc_write;

  always_comb begin
    rdata_d = '0;
    if (rd_hit) begin
      if (region == SEL_ADDR) begin
        rdata_d = addr_q & lane_mask;
      end else if (region == SEL_DATA) begin
        rdata_d = cfg_rdata & lane_mask;
      end
    end
  end

  // Read return path: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_hit) begin
      rdata_q <= rdata_d;
    end
  end

  assign acc_rdata  = rdata_q;
  assign acc_rvalid = rvalid_q;

  AST_REQ_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (acc_valid && (region == SEL_DATA))); // R4

  AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (cfg_be != '0)); // R5

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> acc_rvalid); // R7

  AST_RDATA_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rvalid |-> ((acc_rdata & ~$past(lane_mask)) == '0)); // R7

  AST_BAD_SIZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_size_e'(acc_size) == SZ_BAD)) |-> !cfg_req); // R8

  AST_DP_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |=> $stable(addr_q)); // R9

endmodule

// File: tb/sim_cfg_addr_latch.sv
module sim_cfg_addr_latch;

  logic        clk;
  logic        rst_n;
  logic        acc_valid;
  logic        acc_write;
  logic [2:0]  acc_offset;
  logic [1:0]  acc_size;
  logic [31:0] acc_wdata;
  logic [31:0] acc_rdata;
  logic        acc_rvalid;
  logic        cfg_req;
  logic        cfg_we;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [5:0]  cfg_dword;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;

  int n_tests;
  int n_fail;
  logic [31:0] exp_addr;

  cfg_addr_latch u0 (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_offset(acc_offset),
    .acc_size(acc_size), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .acc_rvalid(acc_rvalid),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
    .cfg_fn(cfg_fn), .cfg_dword(cfg_dword), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] backend(input logic [7:0] b, input logic [4:0] d,
                                          input logic [2:0] f, input logic [5:0] w);
    return 32'h9E37_79B9 ^ {b, d, f, w, 10'h0};
  endfunction

  // Backend model: combinational answer to the request fields
  assign cfg_rdata = backend(cfg_bus, cfg_dev, cfg_fn, cfg_dword);

  function automatic logic [3:0] exp_be(input logic [2:0] off, input logic [1:0] sz);
    logic [7:0] base;
    case (sz)
      2'd0: base = 8'h01;
      2'd1: base = 8'h03;
      2'd2: base = 8'h0F;
      default: base = 8'h00;
    endcase
    base = base << off[1:0];
    return base[3:0];
  endfunction

  function automatic logic [31:0] exp_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // One access: drive on a falling edge, check backend outputs, then read return
  task automatic access(input logic w, input logic [2:0] off, input logic [1:0] sz,
                        input logic [31:0] d, input string rtag);
    logic [3:0]  be;
    logic [31:0] lm;
    logic [31:0] exp_rd;
    logic        dp;
    be = exp_be(off, sz);
    lm = exp_mask(be);
    dp = off[2];
    @(negedge clk);
    acc_valid  = 1'b1;
    acc_write  = w;
    acc_offset = off;
    acc_size   = sz;
    acc_wdata  = d;
    #1;
    if (dp && sz != 2'd3) begin
      chk(cfg_req === 1'b1, "R4 req", {31'h0, cfg_req}, 32'h1);
      chk(cfg_bus === exp_addr[23:16], "R4 bus", {24'h0, cfg_bus}, {24'h0, exp_addr[23:16]});
      chk(cfg_dev === exp_addr[15:11], "R4 dev", {27'h0, cfg_dev}, {27'h0, exp_addr[15:11]});
      chk(cfg_fn === exp_addr[10:8], "R4 fn", {29'h0, cfg_fn}, {29'h0, exp_addr[10:8]});
      chk(cfg_dword === exp_addr[7:2], "R4 dword", {26'h0, cfg_dword}, {26'h0, exp_addr[7:2]});
      chk(cfg_be === be, "R5 be", {28'h0, cfg_be}, {28'h0, be});
      chk(cfg_we === w, "R6 we", {31'h0, cfg_we}, {31'h0, w});
      if (w) chk(cfg_wdata === (d & lm), "R6 wdata", cfg_wdata, d & lm);
    end else begin
      chk(cfg_req === 1'b0, (sz == 2'd3) ? "R8 no req" : "R4 no req",
          {31'h0, cfg_req}, 32'h0);
    end
    if (w && !dp && off == 3'd0 && sz == 2'd2) begin
      exp_addr = (d & 32'hFFFF_FFFC) | 32'h8000_0000;
    end
    if (!w) begin
      exp_rd = dp ? (backend(exp_addr[23:16], exp_addr[15:11], exp_addr[10:8],
                             exp_addr[7:2]) & lm)
                  : (exp_addr & lm);
    end else begin
      exp_rd = 32'h0;
    end
    @(negedge clk);
    if (!w) begin
      chk(acc_rvalid === 1'b1, "R7 rvalid", {31'h0, acc_rvalid}, 32'h1);
      chk(acc_rdata === exp_rd, rtag, acc_rdata, exp_rd);
    end else begin
      chk(acc_rvalid === 1'b0, "R7 no rvalid after write", {31'h0, acc_rvalid}, 32'h0);
    end
    acc_valid = 1'b0;
  endtask

  logic [31:0] vals [4];

  initial begin
    bit wd_fired;
    wd_fired = 1'b0;
    fork
      begin
        repeat (200000) @(posedge clk);
        wd_fired = 1'b1;
      end
      begin
        n_tests   = 0;
        n_fail    = 0;
        exp_addr  = 32'h0;
        acc_valid = 1'b0;
        acc_write = 1'b0;
        acc_offset = 3'd0;
        acc_size  = 2'd0;
        acc_wdata = 32'h0;
        rst_n     = 1'b0;
        vals[0] = 32'h0012_3457;
        vals[1] = 32'hFFFF_FFFF;
        vals[2] = 32'h7F5A_A5F3;
        vals[3] = 32'h00AB_CD02;
        repeat (3) @(negedge clk);
        chk(acc_rvalid === 1'b0, "R1 rvalid in reset", {31'h0, acc_rvalid}, 32'h0);
        chk(cfg_req === 1'b0, "R1 req in reset", {31'h0, cfg_req}, 32'h0);
        rst_n = 1'b1;
        access(1'b0, 3'd0, 2'd2, 32'h0, "R1 address after reset");

        // Address region: every offset and size, several values
        for (int v = 0; v < 4; v++) begin
          for (int o = 0; o < 4; o++) begin
            for (int s = 0; s < 4; s++) begin
              logic [31:0] pat;
              pat = vals[v] ^ {o[7:0], s[7:0], 16'h0};
              access(1'b1, 3'(o), 2'(s), pat, "R3");
              access(1'b0, 3'd0, 2'd2, 32'h0,
                     (o == 0 && s == 2) ? "R2 fixed-up readback" : "R3 register unchanged");
            end
          end
        end

        // Narrow reads of the address register
        access(1'b1, 3'd0, 2'd2, 32'h1234_5678, "R2");
        for (int o = 0; o < 4; o++) begin
          for (int s = 0; s < 4; s++) begin
            access(1'b0, 3'(o), 2'(s), 32'h0, (s == 3) ? "R8 bad-size read" : "R7 narrow read");
          end
        end

        // Data port: every offset and size, both directions, several addresses
        for (int v = 0; v < 4; v++) begin
          access(1'b1, 3'd0, 2'd2, vals[v], "R2");
          for (int o = 4; o < 8; o++) begin
            for (int s = 0; s < 4; s++) begin
              access(1'b1, 3'(o), 2'(s), 32'hC3D2_E1F0 ^ vals[v], "R6");
              access(1'b0, 3'(o), 2'(s), 32'h0, (s == 3) ? "R8 bad-size data read" : "R7 data read");
            end
          end
          access(1'b0, 3'd0, 2'd2, 32'h0, "R9 address kept after data port");
        end
        @(negedge clk);
        chk(acc_rvalid === 1'b0, "R7 rvalid single cycle", {31'h0, acc_rvalid}, 32'h0);
      end
    join_any
    if (wd_fired) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule